// File: doc/BRIEF.md
# Single-Byte EEPROM Write Sequencer

This block updates one location of a parallel EEPROM for each request it takes. A request brings an address and a data byte over a valid/ready handshake. The block first reads the location. If the location already holds the requested byte, the block issues no write and reports at once that it skipped the byte. If the byte differs, the block gives one write strobe and then polls the same address. While the device is busy, a read returns the most significant data bit inverted. The write is finished once a read returns the whole byte unchanged.

Each request ends with a one-cycle response strobe and a two-bit result code. The poll loop runs for up to a set number of clocks, so it can ride out the one to several milliseconds that a device-internal write takes. If the byte has not settled when that limit is reached, the block reports a timeout. Every parameter is set per instance: the read access time, the write strobe width, the gap between poll reads and the timeout.

Top module: `eeprom_byte_prog`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and mem_ce_n, mem_oe_n and mem_we_n are all 1. The bus stays quiet (mem_ce_n = 1) whenever req_ready is 1.
- R2: A request is taken only on a clock where req_valid and req_ready are both 1. req_ready then stays 0 until the response for that request has been given. A request held valid during an operation is not taken before that operation's response.
- R3: Every request starts with a read of its address (mem_oe_n = 0 and mem_ce_n = 0 for RD_CYC clocks). If the byte read equals the request data, no write strobe is issued and the response code is 0 (skipped).
- R4: If the byte differs, exactly one write strobe is issued. It is mem_we_n = 0 for WE_CYC consecutive clocks, with mem_ce_n = 0 and mem_oe_n = 1. mem_addr and mem_wdata do not change during the strobe.
- R5: After the strobe, the address is polled with reads of RD_CYC clocks, and each read is preceded by POLL_GAP clocks with the bus deselected. mem_we_n stays 1 throughout. A read whose bit 7 is inverted compared with the data counts as busy.
- R6: A poll read that returns the full requested byte ends the request with code 1 (written and verified). The device then holds the new byte.
- R7: If no matching poll read has been seen after TIMEOUT_CYC clocks of polling, the request ends with code 2 (timeout), one clock later.
- R8: Each accepted request produces exactly one response: rsp_valid is high for a single clock, with rsp_code set to 0, 1 or 2 and never 3. The block is ready again on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address to program |
| req_data | input | DATA_W | Byte value wanted at req_addr |
| rsp_valid | output | 1 | One-clock result strobe |
| rsp_code | output | 2 | 0 skipped, 1 written and verified, 2 timeout |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The assertions take for granted that the memory returns valid read data combinationally, within the RD_CYC clocks the block holds a read. They also assume req_addr and req_data are valid whenever req_valid is high. The bench's memory model answers in the same cycle and inverts bit 7 while a write is busy. Its busy time per request ranges from zero clocks to just under the timeout. It also has a mode in which the write never completes, which drives the timeout path. The driver changes request fields only on falling edges and keeps req_valid high until the handshake. As a result, a request is often held valid while the previous one is still in progress.

// File: rtl/eeprom_byte_prog.sv
module eeprom_byte_prog #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int RD_CYC      = 2,
  parameter int WE_CYC      = 4,
  parameter int POLL_GAP    = 16,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int CW = $clog2(POLL_GAP + RD_CYC + WE_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] RD_END  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WE_END  = CW'(WE_CYC - 1);
  localparam logic [CW-1:0] GAP_N   = CW'(POLL_GAP);
  localparam logic [CW-1:0] PL_END  = CW'(POLL_GAP + RD_CYC - 1);
  localparam logic [TW-1:0] TO_END  = TW'(TIMEOUT_CYC - 1);
  localparam logic [1:0] C_SKIP = 2'd0, C_OK = 2'd1, C_TMO = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RDCMP, S_WRITE, S_POLL, S_DONE, S_ERR} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [TW-1:0]     tcnt;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [1:0]        code_q;

  wire hit = (mem_rdata == d_q);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE) || (st == S_ERR);
  assign rsp_code  = code_q;
  assign mem_addr  = a_q;
  assign mem_wdata = d_q;
  assign mem_oe_n  = !((st == S_RDCMP) || (st == S_POLL && cnt >= GAP_N));
  assign mem_we_n  = (st != S_WRITE);
  assign mem_ce_n  = mem_oe_n && mem_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tcnt   <= '0;
      a_q    <= '0;
      d_q    <= '0;
      code_q <= C_SKIP;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr;
          d_q <= req_data;
          cnt <= '0;
          st  <= S_RDCMP;
        end
        S_RDCMP: if (cnt == RD_END) begin
          cnt <= '0;
          if (hit) begin
            code_q <= C_SKIP;
            st     <= S_DONE;
          end else begin
            st <= S_WRITE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_WRITE: if (cnt == WE_END) begin
          cnt  <= '0;
          tcnt <= '0;
          st   <= S_POLL;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_POLL: begin
          tcnt <= tcnt + 1'b1;
          if (cnt == PL_END && hit) begin
            code_q <= C_OK;
            st     <= S_DONE;
          end else if (tcnt == TO_END) begin
            code_q <= C_TMO;
            st     <= S_ERR;
          end else begin
            cnt <= (cnt == PL_END) ? '0 : cnt + 1'b1;
          end
        end
        S_DONE, S_ERR: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_byte_prog_chk.sv
module eeprom_byte_prog_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int WE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);

  logic [31:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || mem_we_n) lo_cnt <= '0;
    else                    lo_cnt <= lo_cnt + 32'd1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n && mem_we_n);

  a_r2_taken_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r4_we_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n && mem_oe_n);

  a_r4_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr) && $stable(mem_wdata));

  a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> lo_cnt == 32'(WE_CYC));

  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code != 2'd3);

endmodule

bind eeprom_byte_prog eeprom_byte_prog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_CYC(WE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n)
);

// File: tb/eeprom_byte_prog_bench.sv
module eeprom_byte_prog_bench;
  localparam int AW = 8, DW = 8, RD = 2, WE = 3, GAP = 4, TMO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, rsp_valid;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [DW-1:0] req_data = '0, mem_wdata, mem_rdata;
  logic [1:0] rsp_code;
  logic mem_ce_n, mem_oe_n, mem_we_n;

  always #4 clk = ~clk;

  eeprom_byte_prog #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WE_CYC(WE),
    .POLL_GAP(GAP), .TIMEOUT_CYC(TMO)) u_eeprom_byte_prog (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n));

  // memory model: bit 7 reads inverted while a write is busy
  logic [DW-1:0] mem [256];
  logic [DW-1:0] ref_mem [256];
  logic pend = 1'b0, hang = 1'b0;
  logic [AW-1:0] pa = '0;
  logic [DW-1:0] pd = '0;
  int busy_len = 0, bcnt = 0;

  always_comb begin
    if (!mem_ce_n && !mem_oe_n)
      mem_rdata = (pend && pa == mem_addr) ? {~pd[7], pd[6:0]} : mem[mem_addr];
    else
      mem_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (req_valid && req_ready) pend <= 1'b0;
    else if (!mem_we_n && !mem_ce_n) begin
      pend <= 1'b1; pa <= mem_addr; pd <= mem_wdata; bcnt <= busy_len;
    end else if (pend && !hang) begin
      if (bcnt == 0) begin mem[pa] <= pd; pend <= 1'b0; end
      else bcnt <= bcnt - 1;
    end
  end

  int total = 0, bad = 0, n_acc = 0, n_rsp = 0;
  int q_code[$], q_we[$], q_addr[$], q_mem[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int a, input int d, input int bl, input bit hg);
    int code;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_data = DW'(d);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    busy_len = bl; hang = hg;
    chk(n_rsp == n_acc, "R2 taken only after prior response", n_rsp, n_acc);
    n_acc++;
    if (ref_mem[a] == DW'(d)) code = 0;
    else if (hg) code = 2;
    else code = 1;
    q_code.push_back(code);
    q_we.push_back(code == 0 ? 0 : 1);
    q_addr.push_back(a);
    if (code == 1) ref_mem[a] = DW'(d);
    q_mem.push_back(int'(ref_mem[a]));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  int we_falls = 0, we_seen = 0, lo = 0, since = 0, overlap = 0, poll_rd = 0;
  logic prev_we = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n && prev_we) we_falls++;
      if (!mem_we_n) begin lo++; since = 0; end
      else begin
        if (!prev_we) chk(lo == WE, "R4 write strobe width", lo, WE);
        lo = 0; since++;
      end
      if (!mem_oe_n && !mem_we_n) overlap++;
      if (!mem_oe_n && pend) poll_rd++;
      prev_we = mem_we_n;
      if (rsp_valid) begin
        int ec, ew, ea, em;
        n_rsp++;
        if (q_code.size() == 0) chk(0, "R8 response without request", 1, 0);
        else begin
          ec = q_code.pop_front(); ew = q_we.pop_front();
          ea = q_addr.pop_front(); em = q_mem.pop_front();
          chk(rsp_code == 2'(ec), ec == 0 ? "R3 code skipped" :
              (ec == 1 ? "R6 code written" : "R7 code timeout"), rsp_code, ec);
          chk(we_falls - we_seen == ew, ec == 0 ? "R3 no write strobe" :
              "R4 single write strobe", we_falls - we_seen, ew);
          chk(mem[ea] == DW'(em), "R6 device content", mem[ea], em);
          if (ec == 2)
            chk(since >= TMO && since <= TMO + 2, "R7 timeout latency", since, TMO + 1);
        end
        we_seen = we_falls;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = DW'(i) ^ 8'hC3;
      ref_mem[i] = DW'(i) ^ 8'hC3;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
    chk(mem_ce_n == 1'b1, "R1 ce_n high", mem_ce_n, 1);
    chk(mem_oe_n == 1'b1, "R1 oe_n high", mem_oe_n, 1);
    chk(mem_we_n == 1'b1, "R1 we_n high", mem_we_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n == 1'b1, "R1 idle bus quiet", mem_ce_n, 1);

    send(8'h10, 8'hD3, 0, 0);     // already equal
    send(8'h11, 8'h80, 5, 0);
    send(8'h12, 8'h7F, 40, 0);
    send(8'h12, 8'h7F, 0, 0);     // now equal
    send(8'h13, 8'h00, 0, 0);
    send(8'h14, 8'hFF, 200, 0);
    send(8'h15, 8'h33, 0, 1);     // never completes
    send(8'h15, 8'h44, 3, 0);
    send(8'hFF, 8'hA5, 10, 0);
    send(8'h00, 8'hC3, 0, 0);     // already equal
    while (n_rsp < n_acc) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_rsp == 10, "R8 one response per request", n_rsp, 10);
    chk(overlap == 0, "R5 no read during write strobe", overlap, 0);
    chk(poll_rd > 0, "R5 poll reads while busy", poll_rd, 1);
    chk(req_ready == 1'b1, "R8 ready after last response", req_ready, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule